// File: doc/BRIEF.md
# Broadcast-tag operand wakeup window

This block is the operand-delivery part of a dataflow instruction window. Each entry of the window represents one instruction that waits for up to two operands, called A and B. Operands arrive over two paths. The first is an explicit lane that carries one value and up to two direct targets, each naming an entry and a slot. The second is a broadcast lane for high-fanout values. This lane carries a 3-bit send tag, a slot selector and a value. Each entry compares that tag against its own statically loaded receive tag, so one broadcast can fill the same slot in any number of entries in a single cycle.

Entries are loaded through a configuration port with their static fields: receive tag, a receive-enable bit, and a two-bit mask of the operands they need. The window raises a per-entry ready flag once every needed operand is present. It issues the lowest-index ready entry each cycle through a registered issue port that carries both operand values. A block flush empties every operand slot and clears every issued mark, but the static fields survive. The next block instance can therefore reuse the loaded window.

Top module: `opb_wakeup_window`

## Requirements
- R1: An explicit target with its enable set writes the lane value into the named entry's slot; slot code 0 selects operand A, code 1 selects operand B.
- R2: Both explicit targets of one result take effect in the same cycle, and each may name a different entry or slot.
- R3: A broadcast with send tag T and slot code S writes its value into slot S of every loaded entry whose receive tag equals T, all in the same cycle.
- R4: An entry whose receive-enable bit is clear never captures a broadcast, whatever its receive tag.
- R5: The tag space has 8 values (3 bits), and a broadcast matches only on exact equality of the whole tag.
- R6: When the explicit lane and the broadcast lane write the same slot of the same entry in one cycle, the explicit value is kept.
- R7: Bit i of `rdy_vec` is 1 when entry i is loaded, not issued, and holds every operand named in its need mask (bit 0 = A, bit 1 = B), and only then. The bit is visible in the cycle after the write that completes it.
- R8: One clock edge after `rdy_vec` is nonzero, the issue port presents the lowest-index ready entry with both operand values. That entry is then marked issued and does not issue again until a flush or a reload.
- R9: A flush clears all operand-present and issued marks and keeps the receive tags, enables and need masks. It overrides operand writes in the same cycle and suppresses the issue that would occur at that edge.
- R10: After reset no entry is loaded, `rdy_vec` is zero and `iss_valid` is low.
- R11: A configuration write loads an entry's static fields and clears its present and issued marks. It overrides operand writes to that entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all operand slots and issued marks |
| cfg_we | input | 1 | Load static fields of one entry |
| cfg_idx | input | 5 | Entry to load |
| cfg_rx_tag | input | 3 | Receive tag for the entry |
| cfg_rx_ok | input | 1 | Receive-enable for the entry |
| cfg_need | input | 2 | Needed operands, bit 0 = A, bit 1 = B |
| ex_data | input | 32 | Explicit lane value |
| ex_t0_en | input | 1 | First target enable |
| ex_t0_idx | input | 5 | First target entry |
| ex_t0_slot | input | 1 | First target slot, 0 = A, 1 = B |
| ex_t1_en | input | 1 | Second target enable |
| ex_t1_idx | input | 5 | Second target entry |
| ex_t1_slot | input | 1 | Second target slot |
| bc_en | input | 1 | Broadcast valid |
| bc_tag | input | 3 | Broadcast send tag |
| bc_slot | input | 1 | Broadcast slot, 0 = A, 1 = B |
| bc_data | input | 32 | Broadcast value |
| rdy_vec | output | 32 | Per-entry ready flags |
| iss_valid | output | 1 | Issue port holds an issued entry |
| iss_idx | output | 5 | Index of issued entry |
| iss_opa | output | 32 | Operand A of issued entry |
| iss_opb | output | 32 | Operand B of issued entry |

## Verification
An operand write, a flush or a configuration write presented before edge k shows in `rdy_vec` just after edge k. The matching issue appears on the issue port just after edge k+1. When several entries wake together, they issue on consecutive edges in ascending index order. The bench applies stimulus for exactly one edge and then clears it. It reads `rdy_vec` one edge later and follows each issue edge by edge, so every check falls in the cycle in which its result is due. A sweep covers all eight broadcast tags against a window whose tags repeat every eight entries and whose top four entries do not listen. The expected wake masks, issue order and values are computed arithmetically.

// File: rtl/opb_pkg.sv
package opb_pkg;
  typedef enum logic {SLOT_A = 1'b0, SLOT_B = 1'b1} slot_e;

  function automatic logic [1:0] slot_onehot(input logic hit, input slot_e s);
    return hit ? ((s == SLOT_B) ? 2'b10 : 2'b01) : 2'b00;
  endfunction
endpackage

// File: rtl/opb_low_pick.sv
module opb_low_pick #(
  parameter int N = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  assign gnt = req & (~req + N'(1));
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/opb_slot_entry.sv
module opb_slot_entry
  import opb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              cfg_hit,
  input  logic [TAG_W-1:0]  cfg_tag,
  input  logic              cfg_tag_ok,
  input  logic [1:0]        cfg_need,
  input  logic              ex0_hit,
  input  slot_e             ex0_slot,
  input  logic              ex1_hit,
  input  slot_e             ex1_slot,
  input  logic [DATA_W-1:0] ex_data,
  input  logic              bc_en,
  input  logic [TAG_W-1:0]  bc_tag,
  input  slot_e             bc_slot,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              issue_me,
  output logic              ready,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb
);
  logic             live, tag_ok, issued;
  logic [TAG_W-1:0] rx_tag;
  logic [1:0]       need, present;
  logic             bc_match;
  logic [1:0]       wx, wb;

  assign bc_match = bc_en && live && tag_ok && (rx_tag == bc_tag);
  assign wx = slot_onehot(ex0_hit, ex0_slot) | slot_onehot(ex1_hit, ex1_slot);
  assign wb = slot_onehot(bc_match, bc_slot);
  assign ready = live && !issued && (&(present | ~need));

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= 1'b0;
      tag_ok  <= 1'b0;
      rx_tag  <= '0;
      need    <= 2'b00;
      present <= 2'b00;
      issued  <= 1'b0;
      opa     <= '0;
      opb     <= '0;
    end else if (cfg_hit) begin
      live    <= 1'b1;
      tag_ok  <= cfg_tag_ok;
      rx_tag  <= cfg_tag;
      need    <= cfg_need;
      present <= 2'b00;
      issued  <= 1'b0;
    end else if (flush) begin
      present <= 2'b00;
      issued  <= 1'b0;
    end else begin
      if (issue_me) issued <= 1'b1;
      if (wx[0]) begin
        opa        <= ex_data;
        present[0] <= 1'b1;
      end else if (wb[0]) begin
        opa        <= bc_data;
        present[0] <= 1'b1;
      end
      if (wx[1]) begin
        opb        <= ex_data;
        present[1] <= 1'b1;
      end else if (wb[1]) begin
        opb        <= bc_data;
        present[1] <= 1'b1;
      end
    end
  end

  AST_ISSUE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    issue_me |-> ready); // R8
  AST_LISTEN_GATE: assert property (@(posedge clk) disable iff (rst)
    (bc_en && !tag_ok && !cfg_hit && !flush && !ex0_hit && !ex1_hit) |=> $stable(present)); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (flush && !cfg_hit) |=> (present == 2'b00 && !issued)); // R9
endmodule

// File: rtl/opb_wakeup_window.sv
module opb_wakeup_window
  import opb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [TAG_W-1:0]   cfg_rx_tag,
  input  logic               cfg_rx_ok,
  input  logic [1:0]         cfg_need,
  input  logic [DATA_W-1:0]  ex_data,
  input  logic               ex_t0_en,
  input  logic [IDX_W-1:0]   ex_t0_idx,
  input  logic               ex_t0_slot,
  input  logic               ex_t1_en,
  input  logic [IDX_W-1:0]   ex_t1_idx,
  input  logic               ex_t1_slot,
  input  logic               bc_en,
  input  logic [TAG_W-1:0]   bc_tag,
  input  logic               bc_slot,
  input  logic [DATA_W-1:0]  bc_data,
  output logic [ENTRIES-1:0] rdy_vec,
  output logic               iss_valid,
  output logic [IDX_W-1:0]   iss_idx,
  output logic [DATA_W-1:0]  iss_opa,
  output logic [DATA_W-1:0]  iss_opb
);
  logic [ENTRIES-1:0] ready_w, cfg_hit_w, elig, gnt;
  logic [DATA_W-1:0]  opa_w [ENTRIES];
  logic [DATA_W-1:0]  opb_w [ENTRIES];
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign cfg_hit_w[g] = cfg_we && (cfg_idx == IDX_W'(g));
    assign elig[g]      = ready_w[g] && !flush && !cfg_hit_w[g];

    opb_slot_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
      .clk        (clk),
      .rst        (rst),
      .flush      (flush),
      .cfg_hit    (cfg_hit_w[g]),
      .cfg_tag    (cfg_rx_tag),
      .cfg_tag_ok (cfg_rx_ok),
      .cfg_need   (cfg_need),
      .ex0_hit    (ex_t0_en && (ex_t0_idx == IDX_W'(g))),
      .ex0_slot   (slot_e'(ex_t0_slot)),
      .ex1_hit    (ex_t1_en && (ex_t1_idx == IDX_W'(g))),
      .ex1_slot   (slot_e'(ex_t1_slot)),
      .ex_data    (ex_data),
      .bc_en      (bc_en),
      .bc_tag     (bc_tag),
      .bc_slot    (slot_e'(bc_slot)),
      .bc_data    (bc_data),
      .issue_me   (gnt[g]),
      .ready      (ready_w[g]),
      .opa        (opa_w[g]),
      .opb        (opb_w[g])
    );
  end

  opb_low_pick #(.N(ENTRIES)) u_pick (
    .req (elig),
    .gnt (gnt),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign rdy_vec = ready_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_idx   <= '0;
      iss_opa   <= '0;
      iss_opb   <= '0;
    end else begin
      iss_valid <= pick_any;
      if (pick_any) begin
        iss_idx <= pick_idx;
        iss_opa <= opa_w[pick_idx];
        iss_opb <= opb_w[pick_idx];
      end
    end
  end

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R8
  AST_ISSUE_RETIRES: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !rdy_vec[iss_idx]); // R8
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
    flush |=> !iss_valid); // R9
endmodule

// File: tb/opb_wakeup_window_test.sv
`timescale 1ns/1ps
module opb_wakeup_window_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        flush, cfg_we, cfg_rx_ok;
  logic [4:0]  cfg_idx, ex_t0_idx, ex_t1_idx, iss_idx;
  logic [2:0]  cfg_rx_tag, bc_tag;
  logic [1:0]  cfg_need;
  logic [31:0] ex_data, bc_data, iss_opa, iss_opb, rdy_vec;
  logic        ex_t0_en, ex_t0_slot, ex_t1_en, ex_t1_slot, bc_en, bc_slot, iss_valid;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  opb_wakeup_window uut (
    .clk(clk), .rst(rst), .flush(flush), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_rx_tag(cfg_rx_tag), .cfg_rx_ok(cfg_rx_ok), .cfg_need(cfg_need),
    .ex_data(ex_data), .ex_t0_en(ex_t0_en), .ex_t0_idx(ex_t0_idx), .ex_t0_slot(ex_t0_slot),
    .ex_t1_en(ex_t1_en), .ex_t1_idx(ex_t1_idx), .ex_t1_slot(ex_t1_slot),
    .bc_en(bc_en), .bc_tag(bc_tag), .bc_slot(bc_slot), .bc_data(bc_data),
    .rdy_vec(rdy_vec), .iss_valid(iss_valid), .iss_idx(iss_idx),
    .iss_opa(iss_opa), .iss_opb(iss_opb)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    flush = 0; cfg_we = 0; ex_t0_en = 0; ex_t1_en = 0; bc_en = 0;
  endtask

  task automatic expect_issue(input string req, input int idx, input logic [31:0] a);
    chk(req, {63'd0, iss_valid}, 64'd1);
    chk(req, {59'd0, iss_idx}, 64'(idx));
    chk(req, {32'd0, iss_opa}, {32'd0, a});
  endtask

  task automatic do_flush();
    flush = 1; tick(); flush = 0;
  endtask

  task automatic explicit0(input int idx, input bit slot, input logic [31:0] d);
    ex_t0_en = 1; ex_t0_idx = 5'(idx); ex_t0_slot = slot; ex_data = d;
  endtask

  initial begin
    quiet();
    cfg_idx = 0; cfg_rx_tag = 0; cfg_rx_ok = 0; cfg_need = 0;
    ex_data = 0; ex_t0_idx = 0; ex_t0_slot = 0; ex_t1_idx = 0; ex_t1_slot = 0;
    bc_tag = 0; bc_slot = 0; bc_data = 0;
    rst = 1;
    tick(); tick(); tick();
    rst = 0;
    tick();
    chk("R10 rdy after reset", {32'd0, rdy_vec}, 64'd0);
    chk("R10 issue after reset", {63'd0, iss_valid}, 64'd0);

    // load: tag = i mod 8, listening below 28, need A only
    for (int i = 0; i < 32; i++) begin
      cfg_we = 1; cfg_idx = 5'(i); cfg_rx_tag = 3'(i % 8);
      cfg_rx_ok = (i < 28); cfg_need = 2'b01;
      tick();
    end
    cfg_we = 0;
    tick();
    chk("R7 not ready without operand", {32'd0, rdy_vec}, 64'd0);

    // R3 R4 R5 sweep over all tags
    for (int t = 0; t < 8; t++) begin
      logic [31:0] m;
      do_flush();
      m = '0;
      for (int i = 0; i < 32; i++) m[i] = (i < 28) && (i % 8 == t);
      bc_en = 1; bc_tag = 3'(t); bc_slot = 0; bc_data = 32'hA000 + 32'(t);
      tick();
      bc_en = 0;
      chk("R3 R4 R5 wake mask", {32'd0, rdy_vec}, {32'd0, m});
      for (int i = 0; i < 32; i++) begin
        if (m[i]) begin
          tick();
          expect_issue("R8 ascending issue", i, 32'hA000 + 32'(t));
        end
      end
      tick();
      chk("R8 no reissue", {63'd0, iss_valid}, 64'd0);
      chk("R8 ready drained", {32'd0, rdy_vec}, 64'd0);
    end

    // R3 slot routing: broadcast to B, then explicit A
    do_flush();
    bc_en = 1; bc_tag = 3'd2; bc_slot = 1; bc_data = 32'hBEEF0002;
    tick();
    bc_en = 0;
    chk("R3 B slot not needed", {32'd0, rdy_vec}, 64'd0);
    explicit0(2, 0, 32'h0000_1002);
    tick();
    ex_t0_en = 0;
    chk("R1 explicit A wakes", {32'd0, rdy_vec}, 64'h4);
    tick();
    expect_issue("R1 explicit A value", 2, 32'h0000_1002);
    chk("R3 B slot value", {32'd0, iss_opb}, {32'd0, 32'hBEEF0002});

    // R6 explicit beats broadcast on same slot
    do_flush();
    explicit0(5, 0, 32'h1111);
    bc_en = 1; bc_tag = 3'd5; bc_slot = 0; bc_data = 32'h2222;
    tick();
    quiet();
    chk("R6 wake mask", {32'd0, rdy_vec}, 64'h0020_2020);
    tick(); expect_issue("R6 explicit kept", 5, 32'h1111);
    tick(); expect_issue("R6 broadcast elsewhere", 13, 32'h2222);
    tick(); expect_issue("R6 broadcast elsewhere", 21, 32'h2222);

    // R11 R2 R1: entry 7 needs both; two targets in one result
    do_flush();
    cfg_we = 1; cfg_idx = 5'd7; cfg_rx_tag = 3'd7; cfg_rx_ok = 1; cfg_need = 2'b11;
    tick();
    cfg_we = 0;
    explicit0(7, 1, 32'h44);
    ex_t1_en = 1; ex_t1_idx = 5'd9; ex_t1_slot = 0;
    tick();
    quiet();
    chk("R2 two targets, one complete", {32'd0, rdy_vec}, 64'h200);
    tick(); expect_issue("R2 second target value", 9, 32'h44);
    explicit0(7, 0, 32'h55);
    tick();
    quiet();
    chk("R7 both slots present", {32'd0, rdy_vec}, 64'h80);
    tick(); expect_issue("R1 operand A", 7, 32'h55);
    chk("R1 operand B", {32'd0, iss_opb}, 64'h44);

    // R11 config overrides same-cycle write
    cfg_we = 1; cfg_idx = 5'd12; cfg_rx_tag = 3'd4; cfg_rx_ok = 1; cfg_need = 2'b01;
    explicit0(12, 0, 32'h66);
    tick();
    quiet();
    chk("R11 config wins", {32'd0, rdy_vec}, 64'd0);
    explicit0(12, 0, 32'h67);
    tick();
    quiet();
    chk("R11 reloaded entry wakes", {32'd0, rdy_vec}, 64'h1000);
    tick(); expect_issue("R11 reloaded issue", 12, 32'h67);

    // R9 flush beats writes and pending issue
    flush = 1; explicit0(3, 0, 32'h77);
    tick();
    quiet();
    chk("R9 flush beats write", {32'd0, rdy_vec}, 64'd0);
    explicit0(3, 0, 32'h78);
    tick();
    quiet();
    chk("R9 ready before flush", {32'd0, rdy_vec}, 64'h8);
    flush = 1;
    tick();
    flush = 0;
    chk("R9 issue suppressed", {63'd0, iss_valid}, 64'd0);
    chk("R9 ready cleared", {32'd0, rdy_vec}, 64'd0);
    bc_en = 1; bc_tag = 3'd3; bc_slot = 0; bc_data = 32'h79;
    tick();
    bc_en = 0;
    chk("R9 tags kept after flush", {32'd0, rdy_vec}, 64'h0808_0808);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule